// File: doc/BRIEF.md
# SDRAM Command and Timing Sequencer

This block drives the command pins of one rank of 16-bit single-data-rate SDRAM. Software programs a 32-bit timing word. That word sets the controller enable, the refresh period, the clock-rate select, the four delay fields and the mode-register value. Writing a non-zero command code into the word starts one precharge, refresh or mode-register-set cycle, which is how the memory is brought up before the controller is enabled.

Once enabled, the sequencer takes single-word reads and writes from a valid/ready host port. Each one runs as activate, then read or write with auto-precharge, then a wait before the next activate. Auto-refresh is issued from a free-running interval timer. A refresh that falls due in the middle of an access waits until the access has finished.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the timing word holds 0x0000FFFF, so the controller is disabled and refresh is off. `req_ready` is low, the pins carry NOP, DQM is 2'b11 and `cl_err` is low. Pin codes as {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACT 0011, RD 0101, WR 0100, PRE 0010, REF 0001, MRS 0000.
- R2: A write whose bits [10:9] are non-zero starts one command cycle: 3 gives a precharge with sd_addr[10]=1 (all banks), 2 gives a refresh, 1 gives a mode-register set. Code 0 starts nothing.
- R3: During a mode-register set, sd_addr[15:1] equals timing-word bits [30:16], sd_addr[0]=0 and sd_ba=0.
- R4: Every command is followed by at least one NOP cycle, so two commands are never less than 2 clocks apart.
- R5: Bit 12 selects the 100 MHz mode. The precharge delay tRP is bits[5:4]+1 clocks, or +2 in 100 MHz mode. The RAS-to-CAS delay tRCD is bits[3:2]+1 clocks, or +2 in 100 MHz mode. After a refresh, the next command waits at least bits[7:6]+6 clocks. After a software precharge it waits at least max(tRP,2).
- R6: The CAS latency CL is bits[1:0]+1 in 50 MHz mode and +2 in 100 MHz mode, clamped to 2 or 3. A value of 0 or 3 is illegal at 50 MHz, and a value of 2 or 3 is illegal at 100 MHz. A write that carries an illegal value sets `cl_err`, which stays set until reset.
- R7: An access issues ACT, then RD or WR exactly max(tRCD,2) clocks later with sd_addr[10]=1. The next command comes at least max(CL+tRP,2) clocks after a read and at least tRP+1 clocks after a write.
- R8: The word the memory presents CL clocks after it samples a read appears on `rd_data`, with `rd_valid` high for exactly one cycle. Reads return in request order.
- R9: Bits [15:14] set the refresh interval: 0 gives 52*CYC_PER_US clocks, 1 gives 13*CYC_PER_US clocks, 2 gives 13*CYC_PER_US/2 clocks, and 3 turns refresh off. While the host is idle, refreshes are spaced exactly one interval apart. Any timing-word write restarts the interval.
- R10: A refresh never comes between an ACT and its RD/WR, and it keeps the read/write recovery spacing of R7. Refreshes still happen under continuous host traffic.
- R11: While bit 31 is clear, `req_ready` stays low, no ACT is issued and no auto-refresh is issued.
- R12: `req_addr` is {bank[1:0], row, column}. ACT carries the row on sd_addr[ROW_W-1:0] and the bank on sd_ba. RD/WR carries the column on sd_addr[COL_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and SDRAM clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tw_wr | input | 1 | Timing-word write strobe |
| tw_wdata | input | 32 | Timing-word write value |
| cl_err | output | 1 | Sticky illegal CAS-latency flag |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when high with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2+ROW_W+COL_W | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 16 | Address pins |
| sd_ba | output | 2 | Bank address |
| sd_dqm | output | 2 | Byte masks |
| sd_dq_out | output | 16 | Data driven to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Data from memory |

## Verification
A refresh can fall due in the same cycle that an access is running or that a new request is presented. The bench provokes this by turning on the shortest refresh period and then streaming a long run of back-to-back reads and writes, so that the timer expires at arbitrary points of the access sequence. A pin-level memory model judges every command gap against the delays the bench computes itself, and requires each RD/WR to come directly after its ACT. A scoreboard compares the returned read data with what was written. The bench also confirms that refreshes were issued during the stream.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
   localparam int PIN_W = 16;
   localparam int DQ_W  = 16;
   localparam int BA_W  = 2;
   localparam int CNT_W = 4;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } sd_cmd_t;

   localparam sd_cmd_t CMD_NOP = 4'b0111;
   localparam sd_cmd_t CMD_ACT = 4'b0011;
   localparam sd_cmd_t CMD_RD  = 4'b0101;
   localparam sd_cmd_t CMD_WR  = 4'b0100;
   localparam sd_cmd_t CMD_PRE = 4'b0010;
   localparam sd_cmd_t CMD_REF = 4'b0001;
   localparam sd_cmd_t CMD_MRS = 4'b0000;

   typedef enum logic [1:0] {
      SW_NONE = 2'd0,
      SW_MRS  = 2'd1,
      SW_REF  = 2'd2,
      SW_PRE  = 2'd3
   } sw_cmd_e;

   // effective CAS latency, always 2 or 3
   function automatic logic [2:0] eff_cl(input logic fast, input logic [1:0] f);
      if (fast) return (f == 2'd0) ? 3'd2 : 3'd3;
      else      return (f <= 2'd1) ? 3'd2 : 3'd3;
   endfunction

   function automatic logic cl_bad(input logic fast, input logic [1:0] f);
      if (fast) return f >= 2'd2;
      else      return (f == 2'd0) || (f == 2'd3);
   endfunction
endpackage

// File: rtl/sdseq_timing.sv
module sdseq_timing
   import sdseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast,
   input  logic [1:0]       rc_f,
   input  logic [1:0]       rp_f,
   input  logic [1:0]       rcd_f,
   input  logic [1:0]       cl_f,
   input  logic             wr,
   input  logic             wr_fast,
   input  logic [1:0]       wr_cl,
   output logic [CNT_W-1:0] t_rp,
   output logic [CNT_W-1:0] t_rcd,
   output logic [CNT_W-1:0] t_rc,
   output logic [2:0]       cl_eff,
   output logic             cl_err
);
   logic [CNT_W-1:0] base;

   always_comb begin
      base   = fast ? CNT_W'(2) : CNT_W'(1);
      t_rp   = CNT_W'(rp_f) + base;
      t_rcd  = CNT_W'(rcd_f) + base;
      t_rc   = CNT_W'(rc_f) + CNT_W'(6);
      cl_eff = eff_cl(fast, cl_f);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cl_err <= 1'b0;
      else if (wr && cl_bad(wr_fast, wr_cl)) cl_err <= 1'b1;
   end

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cl_err |=> cl_err);
   assert_err_on_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && cl_bad(wr_fast, wr_cl)) |=> cl_err);
endmodule

// File: rtl/sdseq_refresh.sv
module sdseq_refresh #(
   parameter int CYC_PER_US = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] sel,
   input  logic       ack,
   output logic       due
);
   localparam int LIM_LONG  = 52 * CYC_PER_US;
   localparam int LIM_MID   = 13 * CYC_PER_US;
   localparam int LIM_SHORT = (13 * CYC_PER_US + 1) / 2;
   localparam int CW        = $clog2(LIM_LONG + 1);

   generate
      if (CYC_PER_US < 1) begin : g_bad_rate
         $error("sdseq_refresh: CYC_PER_US must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt, lim;

   always_comb begin
      case (sel)
         2'd0:    lim = CW'(LIM_LONG);
         2'd1:    lim = CW'(LIM_MID);
         default: lim = CW'(LIM_SHORT);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         due <= 1'b0;
      end else if (!run || restart) begin
         cnt <= '0;
         due <= run & due & ~ack;
      end else if (cnt == lim - CW'(1)) begin
         cnt <= '0;
         due <= 1'b1;
      end else begin
         cnt <= cnt + CW'(1);
         if (ack) due <= 1'b0;
      end
   end

   assert_off_no_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !due);
   assert_due_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (due && !ack && run) |=> due);
endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
   import sdseq_pkg::*;
#(
   parameter int ROW_W = 13,
   parameter int COL_W = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        en,
   input  logic                        sw_pend,
   input  logic [1:0]                  sw_kind,
   input  logic [14:0]                 mrs_val,
   input  logic                        ref_due,
   input  logic [CNT_W-1:0]            t_rp,
   input  logic [CNT_W-1:0]            t_rcd,
   input  logic [CNT_W-1:0]            t_rc,
   input  logic [2:0]                  cl_eff,
   input  logic                        req_valid,
   input  logic                        req_we,
   input  logic [BA_W+ROW_W+COL_W-1:0] req_addr,
   input  logic [DQ_W-1:0]             req_wdata,
   input  logic [DQ_W-1:0]             dq_in,
   output logic                        sw_ack,
   output logic                        ref_ack,
   output logic                        req_ready,
   output logic                        rd_valid,
   output logic [DQ_W-1:0]             rd_data,
   output sd_cmd_t                     cmd,
   output logic [PIN_W-1:0]            addr,
   output logic [BA_W-1:0]             ba,
   output logic [1:0]                  dqm,
   output logic [DQ_W-1:0]             dq_out,
   output logic                        dq_oe
);
   localparam int A_W = BA_W + ROW_W + COL_W;
   localparam logic [PIN_W-1:0] AP_BIT = PIN_W'(1) << 10;

   typedef enum logic [1:0] {S_IDLE, S_GAP, S_RW} st_e;

   st_e              st, st_nxt;
   logic [CNT_W-1:0] cnt;
   logic             we_q;
   logic [COL_W-1:0] col_q;
   logic [DQ_W-1:0]  wd_q;
   logic [2:0]       rdl;
   logic             accept;

   assign sw_ack    = (st == S_IDLE) && sw_pend;
   assign ref_ack   = (st == S_IDLE) && !sw_pend && ref_due;
   assign req_ready = (st == S_IDLE) && en && !sw_pend && !ref_due;
   assign accept    = req_ready && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;  st_nxt <= S_IDLE;  cnt <= '0;
         cmd <= CMD_NOP; addr <= '0; ba <= '0; dqm <= 2'b11;
         dq_out <= '0;  dq_oe <= 1'b0;
         we_q <= 1'b0;  col_q <= '0; wd_q <= '0;
         rdl <= '0;     rd_valid <= 1'b0; rd_data <= '0;
      end else begin
         cmd   <= CMD_NOP;
         dq_oe <= 1'b0;
         rd_valid <= 1'b0;
         if (rdl != 3'd0) begin
            rdl <= rdl - 3'd1;
            if (rdl == 3'd1) begin
               rd_valid <= 1'b1;
               rd_data  <= dq_in;
            end
         end
         case (st)
            S_IDLE: begin
               if (sw_pend) begin
                  st <= S_GAP; st_nxt <= S_IDLE;
                  case (sw_kind)
                     SW_PRE:  begin cmd <= CMD_PRE; addr <= AP_BIT; cnt <= t_rp; end
                     SW_REF:  begin cmd <= CMD_REF; cnt <= t_rc; end
                     default: begin
                        cmd <= CMD_MRS; addr <= {mrs_val, 1'b0}; ba <= '0;
                        cnt <= CNT_W'(2);
                     end
                  endcase
               end else if (ref_due) begin
                  cmd <= CMD_REF; cnt <= t_rc; st <= S_GAP; st_nxt <= S_IDLE;
               end else if (accept) begin
                  cmd   <= CMD_ACT;
                  ba    <= req_addr[A_W-1 -: BA_W];
                  addr  <= PIN_W'(req_addr[COL_W +: ROW_W]);
                  dqm   <= 2'b00;
                  we_q  <= req_we;
                  col_q <= req_addr[COL_W-1:0];
                  wd_q  <= req_wdata;
                  cnt   <= t_rcd;
                  st    <= S_GAP; st_nxt <= S_RW;
               end
            end
            S_GAP: begin
               if (cnt <= CNT_W'(2)) begin
                  st <= st_nxt;
                  if (st_nxt == S_IDLE) dqm <= 2'b11;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: begin
               addr <= PIN_W'(col_q) | AP_BIT;
               st <= S_GAP; st_nxt <= S_IDLE;
               if (we_q) begin
                  cmd <= CMD_WR; dq_out <= wd_q; dq_oe <= 1'b1;
                  cnt <= t_rp + CNT_W'(1);
               end else begin
                  cmd <= CMD_RD;
                  cnt <= CNT_W'(cl_eff) + t_rp;
                  rdl <= cl_eff + 3'd1;
               end
            end
         endcase
      end
   end

   assert_nop_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |=> (cmd == CMD_NOP));
   assert_no_ref_in_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_RW) |-> (cmd != CMD_REF));
   assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdseq_pkg::*;
#(
   parameter int CYC_PER_US = 100,
   parameter int ROW_W      = 13,
   parameter int COL_W      = 9
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tw_wr,
   input  logic [31:0]                 tw_wdata,
   output logic                        cl_err,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic                        req_we,
   input  logic [BA_W+ROW_W+COL_W-1:0] req_addr,
   input  logic [DQ_W-1:0]             req_wdata,
   output logic                        rd_valid,
   output logic [DQ_W-1:0]             rd_data,
   output logic                        sd_cs_n,
   output logic                        sd_ras_n,
   output logic                        sd_cas_n,
   output logic                        sd_we_n,
   output logic [PIN_W-1:0]            sd_addr,
   output logic [BA_W-1:0]             sd_ba,
   output logic [1:0]                  sd_dqm,
   output logic [DQ_W-1:0]             sd_dq_out,
   output logic                        sd_dq_oe,
   input  logic [DQ_W-1:0]             sd_dq_in
);
   generate
      if (ROW_W < 11 || ROW_W > 15) begin : g_bad_row
         $error("sdram_cmd_seq: ROW_W must lie in 11..15");
      end
      if (COL_W < 1 || COL_W > 10) begin : g_bad_col
         $error("sdram_cmd_seq: COL_W must lie in 1..10 to keep pin 10 free");
      end
   endgenerate

   logic [31:0]      tw_q;
   logic             sw_pend, sw_ack, ref_due, ref_ack, en, ref_run;
   logic [1:0]       sw_kind;
   logic [CNT_W-1:0] t_rp, t_rcd, t_rc;
   logic [2:0]       cl_eff;
   sd_cmd_t          cmd;
   logic             unused_tw;

   assign unused_tw = ^{tw_q[13], tw_q[11:8]};
   assign en        = tw_q[31];
   assign ref_run   = en && (tw_q[15:14] != 2'd3);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tw_q    <= 32'h0000_FFFF;
         sw_pend <= 1'b0;
         sw_kind <= SW_NONE;
      end else begin
         if (tw_wr) tw_q <= tw_wdata;
         if (tw_wr && tw_wdata[10:9] != 2'd0) begin
            sw_pend <= 1'b1;
            sw_kind <= tw_wdata[10:9];
         end else if (sw_ack) begin
            sw_pend <= 1'b0;
         end
      end
   end

   sdseq_timing u_timing (
      .clk(clk), .rst_n(rst_n), .fast(tw_q[12]),
      .rc_f(tw_q[7:6]), .rp_f(tw_q[5:4]), .rcd_f(tw_q[3:2]), .cl_f(tw_q[1:0]),
      .wr(tw_wr), .wr_fast(tw_wdata[12]), .wr_cl(tw_wdata[1:0]),
      .t_rp(t_rp), .t_rcd(t_rcd), .t_rc(t_rc), .cl_eff(cl_eff), .cl_err(cl_err)
   );

   sdseq_refresh #(.CYC_PER_US(CYC_PER_US)) u_refresh (
      .clk(clk), .rst_n(rst_n), .run(ref_run), .restart(tw_wr),
      .sel(tw_q[15:14]), .ack(ref_ack), .due(ref_due)
   );

   sdseq_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(en), .sw_pend(sw_pend), .sw_kind(sw_kind),
      .mrs_val(tw_q[30:16]), .ref_due(ref_due),
      .t_rp(t_rp), .t_rcd(t_rcd), .t_rc(t_rc), .cl_eff(cl_eff),
      .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .dq_in(sd_dq_in),
      .sw_ack(sw_ack), .ref_ack(ref_ack), .req_ready(req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .cmd(cmd),
      .addr(sd_addr), .ba(sd_ba), .dqm(sd_dqm),
      .dq_out(sd_dq_out), .dq_oe(sd_dq_oe)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

   assert_mrs_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MRS) |-> (sd_addr[15:1] == $past(tw_q[30:16]) && sd_addr[0] == 1'b0));
   assert_ready_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> tw_q[31]);
endmodule

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int CPU        = 100;
   localparam int ROW_W      = 13;
   localparam int COL_W      = 9;
   localparam int A_W        = 2 + ROW_W + COL_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tw_wr = 1'b0;
   logic [31:0]       tw_wdata = '0;
   logic              cl_err;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic              req_we = 1'b0;
   logic [A_W-1:0]    req_addr = '0;
   logic [15:0]       req_wdata = '0;
   logic              rd_valid;
   logic [15:0]       rd_data;
   logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [15:0]       sd_addr;
   logic [1:0]        sd_ba, sd_dqm;
   logic [15:0]       sd_dq_out;
   logic              sd_dq_oe;
   logic [15:0]       sd_dq_in = 16'hDEAD;

   sdram_cmd_seq #(.CYC_PER_US(CPU), .ROW_W(ROW_W), .COL_W(COL_W)) u_sdram_cmd_seq (
      .clk(clk), .rst_n(rst_n), .tw_wr(tw_wr), .tw_wdata(tw_wdata), .cl_err(cl_err),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
      .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // bench copy of the programmed delays, from the requirements
   int trp_b = 2, trcd_b = 2, trc_b = 9, cl_b = 3;
   function automatic void set_cfg(input logic [31:0] w);
      int add;
      add    = w[12] ? 2 : 1;
      trp_b  = int'(w[5:4]) + add;
      trcd_b = int'(w[3:2]) + add;
      trc_b  = int'(w[7:6]) + 6;
      if (w[12]) cl_b = (w[1:0] == 2'd0) ? 2 : 3;
      else       cl_b = (w[1:0] <= 2'd1) ? 2 : 3;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // ---------------- pin-level memory model ----------------
   logic [15:0] mem_m [int];
   logic [15:0] shadow [int];
   logic [A_W-1:0] addr_q [$];
   logic [15:0]    exp_q [$];
   logic [ROW_W-1:0] open_row [4];
   int cyc_n = 0, last_cyc = -1000, rd_at = -1;
   logic [3:0] last_cmd = 4'b0111;
   logic [15:0] rd_word = '0;
   int n_act = 0, n_pre = 0, n_ref = 0, n_mrs = 0, n_cmd = 0;
   int ref_prev = 0, ref_last = 0;
   logic [15:0] pre_addr = '0, mrs_addr = '0;
   logic [1:0]  mrs_ba = 2'b11;

   always @(negedge clk) begin
      logic [3:0] c;
      int gap;
      cyc_n++;
      sd_dq_in = (cyc_n == rd_at) ? rd_word : 16'hDEAD;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (rst_n && c != 4'b0111) begin
         n_cmd++;
         gap = cyc_n - last_cyc;
         chk(gap >= 2, "R4 command spacing", gap, 2);
         case (last_cmd)
            4'b0011: begin
               chk(c == 4'b0101 || c == 4'b0100, "R10 RD/WR follows ACT", c, 4'b0101);
               chk(gap == imax(trcd_b, 2), "R7 ACT to RD/WR", gap, imax(trcd_b, 2));
            end
            4'b0101: chk(gap >= imax(cl_b + trp_b, 2), "R7 after read", gap, cl_b + trp_b);
            4'b0100: chk(gap >= trp_b + 1, "R7 after write", gap, trp_b + 1);
            4'b0001: chk(gap >= trc_b, "R5 after refresh", gap, trc_b);
            4'b0010: chk(gap >= imax(trp_b, 2), "R5 after precharge", gap, trp_b);
            default: ;
         endcase
         case (c)
            4'b0011: begin
               n_act++;
               open_row[sd_ba] = sd_addr[ROW_W-1:0];
               if (addr_q.size() > 0)
                  chk({sd_ba, sd_addr[ROW_W-1:0]} == addr_q[0][A_W-1:COL_W], "R12 ACT bank/row",
                      {sd_ba, sd_addr[ROW_W-1:0]}, addr_q[0][A_W-1:COL_W]);
            end
            4'b0101, 4'b0100: begin
               int key;
               key = int'({sd_ba, open_row[sd_ba], sd_addr[COL_W-1:0]});
               chk(sd_addr[10] == 1'b1, "R7 auto-precharge bit", sd_addr[10], 1);
               if (addr_q.size() > 0) begin
                  chk(sd_addr[COL_W-1:0] == addr_q[0][COL_W-1:0], "R12 column",
                      sd_addr[COL_W-1:0], addr_q[0][COL_W-1:0]);
                  void'(addr_q.pop_front());
               end
               if (c == 4'b0100) begin
                  chk(sd_dq_oe == 1'b1, "R7 write drives data", sd_dq_oe, 1);
                  mem_m[key] = sd_dq_out;
               end else begin
                  rd_word = mem_m.exists(key) ? mem_m[key] : 16'hBEEF;
                  rd_at   = cyc_n + cl_b;
               end
            end
            4'b0010: begin n_pre++; pre_addr = sd_addr; end
            4'b0001: begin n_ref++; ref_prev = ref_last; ref_last = cyc_n; end
            4'b0000: begin n_mrs++; mrs_addr = sd_addr; mrs_ba = sd_ba; end
            default: ;
         endcase
         last_cmd = c;
         last_cyc = cyc_n;
      end
   end

   // ---------------- scoreboard monitor ----------------
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R8 unexpected read data", rd_data, 0);
         else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(rd_data == e, "R8 read data", rd_data, e);
         end
      end
   end

   // ---------------- driver tasks ----------------
   task automatic set_tw(input logic [31:0] w);
      @(negedge clk);
      tw_wr = 1'b1; tw_wdata = w; set_cfg(w);
      @(negedge clk);
      tw_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_access(input bit we, input logic [A_W-1:0] a, input logic [15:0] d);
      @(negedge clk);
      addr_q.push_back(a);
      if (we) shadow[int'(a)] = d;
      else    exp_q.push_back(shadow[int'(a)]);
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   function automatic logic [A_W-1:0] mk_addr(input int k);
      logic [1:0] b;
      logic [ROW_W-1:0] r;
      logic [COL_W-1:0] cc;
      b  = 2'(k);
      r  = ROW_W'(k * 37 + 5);
      cc = COL_W'(k * 11 + 3);
      return {b, r, cc};
   endfunction

   task automatic traffic(input int n, input int seed);
      for (int i = 0; i < 16; i++) do_access(1'b1, mk_addr(i), 16'(i * 4099 + seed));
      for (int i = 0; i < n; i++) begin
         int k;
         k = i % 16;
         if (i % 3 == 0) do_access(1'b1, mk_addr(k), 16'(i * 97 + seed));
         else            do_access(1'b0, mk_addr(k), 16'h0);
      end
      idle(40);
      chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      int base_n, base_act;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1: reset state
      chk(req_ready == 1'b0, "R1 ready after reset", req_ready, 0);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP after reset",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
      chk(sd_dqm == 2'b11, "R1 dqm after reset", sd_dqm, 3);
      chk(cl_err == 1'b0, "R1 error flag after reset", cl_err, 0);
      idle(30);
      chk(n_cmd == 0, "R1 no command while reset value held", n_cmd, 0);

      // R2/R3: initialisation commands, controller still disabled
      set_tw(32'h0000_D655); idle(20);
      chk(n_pre == 1, "R2 precharge issued", n_pre, 1);
      chk(pre_addr[10] == 1'b1, "R2 precharge all banks", pre_addr[10], 1);
      set_tw(32'h0000_D455); idle(20);
      chk(n_ref == 1, "R2 refresh issued", n_ref, 1);
      set_tw(32'h1234_D255); idle(20);
      chk(n_mrs == 1, "R2 mode set issued", n_mrs, 1);
      chk(mrs_addr == 16'h2468, "R3 mode value on pins", mrs_addr, 16'h2468);
      chk(mrs_ba == 2'b00, "R3 bank during mode set", mrs_ba, 0);
      base_n = n_cmd;
      set_tw(32'h0000_D055); idle(20);
      chk(n_cmd == base_n, "R2 code 0 starts nothing", n_cmd, base_n);

      // R11: disabled controller refuses accesses
      base_act = n_act;
      @(negedge clk);
      req_valid = 1'b1; req_we = 1'b0; req_addr = mk_addr(1);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (req_ready) chk(1'b0, "R11 ready while disabled", 1, 0);
      end
      req_valid = 1'b0;
      chk(n_act == base_act, "R11 no activate while disabled", n_act, base_act);

      // R5/R6/R7/R8/R12: 100 MHz mode, CL 3
      set_tw(32'h8000_D055); idle(10);
      chk(cl_err == 1'b0, "R6 legal value leaves flag low", cl_err, 0);
      traffic(40, 11);

      // 50 MHz mode, rp=0 rcd=2 cl=1 -> CL 2
      set_tw(32'h8000_C009); idle(10);
      traffic(40, 22);
      chk(cl_err == 1'b0, "R6 legal 50 MHz value", cl_err, 0);

      // R6: illegal values clamp and set the sticky flag
      set_tw(32'h8000_C008); idle(5);
      chk(cl_err == 1'b1, "R6 cl=0 at 50 MHz flagged", cl_err, 1);
      traffic(20, 33);
      set_tw(32'h8000_C009); idle(5);
      chk(cl_err == 1'b1, "R6 flag sticky", cl_err, 1);
      set_tw(32'h8000_D056); idle(5);
      traffic(20, 44);

      // R9: refresh periods with idle host
      set_tw(32'h8000_9055);
      base_n = n_ref;
      for (int i = 0; i < 3000 && n_ref < base_n + 3; i++) @(negedge clk);
      chk(ref_last - ref_prev == (13 * CPU + 1) / 2, "R9 short interval",
          ref_last - ref_prev, (13 * CPU + 1) / 2);
      set_tw(32'h8000_5055);
      base_n = n_ref;
      for (int i = 0; i < 6000 && n_ref < base_n + 3; i++) @(negedge clk);
      chk(ref_last - ref_prev == 13 * CPU, "R9 medium interval", ref_last - ref_prev, 13 * CPU);
      set_tw(32'h8000_1055);
      base_n = n_ref;
      for (int i = 0; i < 11000 && n_ref < base_n + 2; i++) @(negedge clk);
      chk(n_ref >= base_n + 2, "R9 long interval runs", n_ref, base_n + 2);
      chk(ref_last - ref_prev == 52 * CPU, "R9 long interval", ref_last - ref_prev, 52 * CPU);
      set_tw(32'h8000_D055);
      base_n = n_ref;
      idle(2000);
      chk(n_ref == base_n, "R9 refresh off", n_ref, base_n);

      // R10: refresh under continuous traffic
      set_tw(32'h8000_9055);
      base_n = n_ref;
      traffic(400, 55);
      chk(n_ref > base_n + 2, "R10 refreshes during traffic", n_ref, base_n + 3);

      // R11: no auto-refresh while disabled
      set_tw(32'h0000_9055);
      idle(20);
      base_n = n_ref;
      idle(1500);
      chk(n_ref == base_n, "R11 no refresh while disabled", n_ref, base_n);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule